// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block brings a DDR SDRAM out of power-up. It sits in front of a command controller that turns an abstract 4-bit command code plus an internal address into pin activity on the memory. The sequencer first holds off for a stabilisation interval, whose length is derived from the clock frequency and a time in microseconds. It then walks the memory through the mandatory set-up series: precharge of all banks, extended-mode load that enables the DLL, mode load that resets the DLL, a DLL-lock pause, a second precharge of all banks, two refreshes and a final mode load carrying the operating CAS latency and burst length. Once that series ends it raises a sticky ready flag.

Each command is presented until the controller's present-state code shows that the command is being executed. A command is never timed blindly. The NOP code is the default whenever no step is requesting anything. Cycle waits (stabilisation, DLL lock, refresh cycle time, burst length) use one shared counter that restarts on every state change.

An optional exercise phase follows initialisation. Each rising edge of a slow strobe steps an 8-bit LFSR, issues a WRITE carrying the LFSR value, waits out the burst, issues a READ to the same bank, waits out that burst, moves to the next bank and then waits for the strobe to fall.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low, cmd_o is NOP (0), init_done_o is 0 and wdata_o holds the seed 8'h01.
- R2: After reset is released, cmd_o stays NOP for exactly CLK_MHZ*PWR_US cycles before the first command (PRECHARGE) appears.
- R3: The set-up commands are accepted in this order: PRECHARGE (1) with address bit 10 set; LOAD (2) with bank field 2'b01 and the extended word in bits 11:0; LOAD with bank 2'b00 and the mode word with bit 8 set; PRECHARGE with bit 10 set; REFRESH (3); REFRESH; LOAD with bank 2'b00 and the plain mode word. The bank field is the top two address bits.
- R4: A PRECHARGE, LOAD, REFRESH, WRITE (4) or READ (5) request keeps its code and address unchanged until ctrl_state_i shows the matching code (PRECHARGE 1, LOAD 2, REFRESH 3, ACTIVE 4 for WRITE/READ). It changes in the cycle after that match is seen.
- R5: After the DLL-reset mode load is accepted, cmd_o is NOP for exactly LOCK_CYC cycles, and then the second PRECHARGE appears.
- R6: After each accepted REFRESH, cmd_o is NOP for exactly TRFC_CYC cycles before the next command.
- R7: After the extended load and after the final mode load, the sequencer waits for ctrl_state_i to return to idle (0). init_done_o rises in the cycle after that idle code is first presented.
- R8: Once init_done_o is 1 it stays 1 until reset.
- R9: WRITE and READ are never issued before init_done_o. Each rising edge of test_strobe_i after initialisation yields exactly one WRITE followed by one READ.
- R10: After an accepted WRITE, cmd_o is NOP for exactly BURST_CYC cycles before the READ appears.
- R11: The WRITE and READ of the k-th exercise pair (k from 0) carry bank field k mod 4 and zero in all lower address bits. A new pair starts only after test_strobe_i has been seen low.
- R12: The LFSR steps once before each WRITE, using next = {q[6:0], q[7]^q[5]^q[4]^q[3]}. wdata_o at the k-th WRITE is the seed stepped k+1 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_state_i | input | 4 | Present-state code of the downstream command controller |
| test_strobe_i | input | 1 | Slow strobe pacing the exercise phase (asynchronous, synchronised inside) |
| cmd_o | output | 4 | Command code requested from the controller |
| addr_o | output | ADDR_W | Internal address; top BANK_W bits are the bank field |
| wdata_o | output | DATA_W | Current LFSR value used as write data |
| init_done_o | output | 1 | Set once the power-up series has completed |

## Verification
Every timing result is measured in negative-edge samples as a run of NOP codes between two commands. The bench expects CLK_MHZ*PWR_US NOPs counted from the first clock edge after reset release, LOCK_CYC NOPs after the DLL-reset load, TRFC_CYC NOPs after each refresh and BURST_CYC NOPs between a WRITE and its READ. The model controller reacts on the falling edge, so a command seen as matched there must change at the very next sample, and one not matched must repeat unchanged. The ready flag must appear exactly one sample after the model returns to idle following the last mode load. Random stalls and hold lengths in the model move these points around, but each expected value is still stated relative to the sample where the model acted.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
// Shared codes for the power-up sequencer.
// Assumes the controller reports its present state with the CST_* codes below.
package ddr_init_pkg;

    typedef enum logic [3:0] {
        CMD_NOP       = 4'd0,
        CMD_PRECHARGE = 4'd1,
        CMD_LOAD_MODE = 4'd2,
        CMD_REFRESH   = 4'd3,
        CMD_WRITE     = 4'd4,
        CMD_READ      = 4'd5
    } cmd_e;

    localparam logic [3:0] CST_IDLE      = 4'd0;
    localparam logic [3:0] CST_PRECHARGE = 4'd1;
    localparam logic [3:0] CST_LOAD      = 4'd2;
    localparam logic [3:0] CST_REFRESH   = 4'd3;
    localparam logic [3:0] CST_ACTIVE    = 4'd4;

    typedef enum logic [4:0] {
        ST_PWR, ST_NOP, ST_PRE1, ST_EMR, ST_EMR_GAP, ST_MR_RST, ST_LOCK,
        ST_PRE2, ST_RFS1, ST_RFS1_GAP, ST_RFS2, ST_RFS2_GAP, ST_MR_OP,
        ST_MR_GAP, ST_READY, ST_T_STEP, ST_T_WR, ST_T_WR_WAIT, ST_T_RD,
        ST_T_RD_WAIT, ST_T_DONE
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_cycle_counter.sv
`timescale 1ns/1ps
// Free-running up counter that restarts at zero when clr is high.
// Assumes the caller never needs to count past 2**W-1 within one state.
module seq_cycle_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count cycles spent in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/seq_lfsr.sv
`timescale 1ns/1ps
// Fibonacci LFSR: shifts left and feeds back the XOR of the masked bits.
// Assumes TAPS describes a maximal-length polynomial and SEED is non-zero.
module seq_lfsr #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  TAPS = 8'hB8,
    parameter logic [W-1:0]  SEED = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] q
);

    logic fb;

    // Feedback bit from the tap mask.
    always_comb fb = ^(q & TAPS);

    // Load the seed on reset, shift on request.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= SEED;
        else if (step) q <= {q[W-2:0], fb};
    end

endmodule

// File: rtl/seq_strobe_sync.sv
`timescale 1ns/1ps
// Two-stage synchroniser for the slow test strobe plus a rising-edge pulse.
// Assumes the strobe stays at each level for several clock cycles.
module seq_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic level_o,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Resample the strobe into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Level and single-cycle rising-edge indication.
    always_comb begin
        level_o = sync_q[STAGES-1];
        rise_o  = sync_q[STAGES-1] & ~prev_q;
    end

endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
// Power-up sequencer for a DDR SDRAM command controller.
// Presents one command at a time and holds it until ctrl_state_i shows the
// controller executing it; counts stabilisation, DLL-lock, refresh and burst
// waits with one shared counter. Optional exercise phase after set-up.
// Assumes the controller leaves a refresh state within TRFC_CYC cycles and
// passes through ACTIVE exactly once per WRITE or READ.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int                CLK_MHZ     = 100,
    parameter int                PWR_US      = 200,
    parameter int                LOCK_CYC    = 200,
    parameter int                TRFC_CYC    = 10,
    parameter int                BURST_CYC   = 4,
    parameter int                ADDR_W      = 23,
    parameter int                BANK_W      = 2,
    parameter int                MODE_W      = 12,
    parameter logic [MODE_W-1:0] MODE_WORD   = 12'h022,
    parameter logic [MODE_W-1:0] EXT_WORD    = 12'h000,
    parameter int                DLL_RST_BIT = 8,
    parameter int                PRE_ALL_BIT = 10,
    parameter int                DATA_W      = 8,
    parameter logic [DATA_W-1:0] LFSR_TAPS   = 8'hB8,
    parameter logic [DATA_W-1:0] LFSR_SEED   = 8'h01,
    parameter bit                TEST_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        ctrl_state_i,
    input  logic              test_strobe_i,
    output logic [3:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              init_done_o
);

    localparam int PWR_CYC = CLK_MHZ * PWR_US;
    localparam int CNT_MAX = max2(max2(PWR_CYC, LOCK_CYC), max2(TRFC_CYC, BURST_CYC));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BANK_LSB = ADDR_W - BANK_W;

    localparam logic [CNT_W-1:0] PWR_LAST   = CNT_W'(PWR_CYC - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYC - 1);
    localparam logic [CNT_W-1:0] TRFC_LAST  = CNT_W'(TRFC_CYC - 1);
    localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_CYC - 1);

    seq_state_e         state_q, state_nxt;
    logic [CNT_W-1:0]   cnt;
    logic               cnt_clr;
    logic               strobe_lvl, strobe_rise;
    logic               lfsr_step;
    logic [BANK_W-1:0]  bank_q;
    logic               bank_inc;
    logic               done_q;
    cmd_e               cmd_c;
    logic [ADDR_W-1:0]  addr_c;

    seq_cycle_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    seq_lfsr #(.W(DATA_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (lfsr_step),
        .q     (wdata_o)
    );

    seq_strobe_sync #(.STAGES(2)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (test_strobe_i),
        .level_o  (strobe_lvl),
        .rise_o   (strobe_rise)
    );

    // Next-state selection: handshake on controller state or counter expiry.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_PWR:       if (cnt == PWR_LAST) state_nxt = ST_NOP;
            ST_NOP:       state_nxt = ST_PRE1;
            ST_PRE1:      if (ctrl_state_i == CST_PRECHARGE) state_nxt = ST_EMR;
            ST_EMR:       if (ctrl_state_i == CST_LOAD) state_nxt = ST_EMR_GAP;
            ST_EMR_GAP:   if (ctrl_state_i == CST_IDLE) state_nxt = ST_MR_RST;
            ST_MR_RST:    if (ctrl_state_i == CST_LOAD) state_nxt = ST_LOCK;
            ST_LOCK:      if (cnt == LOCK_LAST) state_nxt = ST_PRE2;
            ST_PRE2:      if (ctrl_state_i == CST_PRECHARGE) state_nxt = ST_RFS1;
            ST_RFS1:      if (ctrl_state_i == CST_REFRESH) state_nxt = ST_RFS1_GAP;
            ST_RFS1_GAP:  if (cnt == TRFC_LAST) state_nxt = ST_RFS2;
            ST_RFS2:      if (ctrl_state_i == CST_REFRESH) state_nxt = ST_RFS2_GAP;
            ST_RFS2_GAP:  if (cnt == TRFC_LAST) state_nxt = ST_MR_OP;
            ST_MR_OP:     if (ctrl_state_i == CST_LOAD) state_nxt = ST_MR_GAP;
            ST_MR_GAP:    if (ctrl_state_i == CST_IDLE) state_nxt = ST_READY;
            ST_READY:     if (TEST_EN && strobe_rise) state_nxt = ST_T_STEP;
            ST_T_STEP:    state_nxt = ST_T_WR;
            ST_T_WR:      if (ctrl_state_i == CST_ACTIVE) state_nxt = ST_T_WR_WAIT;
            ST_T_WR_WAIT: if (cnt == BURST_LAST) state_nxt = ST_T_RD;
            ST_T_RD:      if (ctrl_state_i == CST_ACTIVE) state_nxt = ST_T_RD_WAIT;
            ST_T_RD_WAIT: if (cnt == BURST_LAST) state_nxt = ST_T_DONE;
            ST_T_DONE:    if (!strobe_lvl) state_nxt = ST_READY;
            default:      state_nxt = ST_PWR;
        endcase
    end

    // Side strobes derived from the current state and transition.
    always_comb begin
        cnt_clr   = (state_nxt != state_q);
        lfsr_step = (state_q == ST_T_STEP);
        bank_inc  = (state_q == ST_T_RD_WAIT) && (state_nxt == ST_T_DONE);
    end

    // State, bank counter and ready flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR;
            bank_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            if (bank_inc) bank_q <= bank_q + 1'b1;
            if (state_nxt == ST_READY) done_q <= 1'b1;
        end
    end

    // Command code and address requested in each state.
    always_comb begin
        cmd_c  = CMD_NOP;
        addr_c = '0;
        unique case (state_q)
            ST_PRE1, ST_PRE2: begin
                cmd_c = CMD_PRECHARGE;
                addr_c[PRE_ALL_BIT] = 1'b1;
            end
            ST_EMR: begin
                cmd_c = CMD_LOAD_MODE;
                addr_c[ADDR_W-1:BANK_LSB] = BANK_W'(1);
                addr_c[MODE_W-1:0] = EXT_WORD;
            end
            ST_MR_RST: begin
                cmd_c = CMD_LOAD_MODE;
                addr_c[MODE_W-1:0] = MODE_WORD;
                addr_c[DLL_RST_BIT] = 1'b1;
            end
            ST_MR_OP: begin
                cmd_c = CMD_LOAD_MODE;
                addr_c[MODE_W-1:0] = MODE_WORD;
            end
            ST_RFS1, ST_RFS2: cmd_c = CMD_REFRESH;
            ST_T_WR: begin
                cmd_c = CMD_WRITE;
                addr_c[ADDR_W-1:BANK_LSB] = bank_q;
            end
            ST_T_RD: begin
                cmd_c = CMD_READ;
                addr_c[ADDR_W-1:BANK_LSB] = bank_q;
            end
            default: begin
                cmd_c  = CMD_NOP;
                addr_c = '0;
            end
        endcase
    end

    // Drive the ports.
    always_comb begin
        cmd_o       = cmd_c;
        addr_o      = addr_c;
        init_done_o = done_q;
    end

endmodule

// File: rtl/ddr_init_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the power-up sequencer, bound to every instance.
// Assumes the controller state codes of ddr_init_pkg.
module ddr_init_seq_chk #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        ctrl_state_i,
    input logic [3:0]        cmd_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] wdata_o,
    input logic              init_done_o
);

    // R4: an unmatched request is held with its address.
    p_hold_request_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o inside {4'd1, 4'd2, 4'd3} && ctrl_state_i != cmd_o) ||
        (cmd_o inside {4'd4, 4'd5} && ctrl_state_i != 4'd4)
        |=> $stable(cmd_o) && $stable(addr_o));

    // R3: every accepted mode load is followed by a NOP.
    p_load_ack_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd2 && ctrl_state_i == 4'd2) |=> cmd_o == 4'd0);

    // R6: every accepted refresh is followed by a NOP.
    p_refresh_ack_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd3 && ctrl_state_i == 4'd3) |=> cmd_o == 4'd0);

    // R10: an accepted WRITE is followed by a NOP.
    p_write_ack_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd4 && ctrl_state_i == 4'd4) |=> cmd_o == 4'd0);

    // R8: the ready flag never falls outside reset.
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(init_done_o));

    // R9: data commands only after set-up.
    p_rw_after_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 4'd4 || cmd_o == 4'd5) |-> init_done_o);

    // R12: the LFSR never reaches the all-zero lock-up state.
    p_lfsr_nonzero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_o != '0);

endmodule

bind ddr_init_seq ddr_init_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_state_i (ctrl_state_i),
    .cmd_o        (cmd_o),
    .addr_o       (addr_o),
    .wdata_o      (wdata_o),
    .init_done_o  (init_done_o)
);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
// Bench: model controller with random stalls and hold times, directed and
// random strobe pulses, expected values computed from the requirements.
module ddr_init_seq_test;

    localparam int CLK_MHZ  = 50;
    localparam int PWR_US   = 200;
    localparam int PWR_CYC  = CLK_MHZ * PWR_US;
    localparam int LOCK_CYC = 200;
    localparam int TRFC_CYC = 10;
    localparam int BURST    = 4;
    localparam int ADDR_W   = 23;
    localparam int PAIRS    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [3:0]        ctrl_state = 4'd0;
    logic              strobe = 1'b0;
    logic [3:0]        cmd;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata;
    logic              done;

    int checks = 0;
    int fails  = 0;
    bit mon_go = 1'b0;
    bit timeout = 1'b0;

    ddr_init_seq #(.CLK_MHZ(CLK_MHZ), .PWR_US(PWR_US), .LOCK_CYC(LOCK_CYC),
                   .TRFC_CYC(TRFC_CYC), .BURST_CYC(BURST)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_state_i  (ctrl_state),
        .test_strobe_i (strobe),
        .cmd_o         (cmd),
        .addr_o        (addr),
        .wdata_o       (wdata),
        .init_done_o   (done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] lfsr_next(input logic [7:0] v);
        return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
    endfunction

    function automatic logic [3:0] exp_init_cmd(input int i);
        case (i)
            0, 3:    return 4'd1;
            4, 5:    return 4'd3;
            default: return 4'd2;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] exp_init_addr(input int i);
        case (i)
            0, 3:    return ADDR_W'(1) << 10;
            1:       return {2'b01, 21'h0};
            2:       return ADDR_W'(12'h122);
            6:       return ADDR_W'(12'h022);
            default: return '0;
        endcase
    endfunction

    // Monitor state
    int          sample = 0;
    int          nop_run = 0;
    logic [3:0]  prev_cmd = 4'd0;
    logic [3:0]  last_non = 4'hF;
    logic [ADDR_W-1:0] prev_addr = '0;
    bit          prev_req = 1'b0;
    bit          prev_ack = 1'b0;
    int          acc_idx = 0;
    int          stall = 0;
    int          hold = 0;
    logic [3:0]  pend_rw = 4'd0;
    int          loads = 0;
    int          idle_sample = -10;
    bit          done_seen = 1'b0;
    logic [7:0]  exp_data = 8'h01;
    logic [3:0]  c;
    logic [ADDR_W-1:0] a;

    // Model controller and protocol monitor, acting on falling edges.
    initial begin
        wait (mon_go);
        forever begin
            @(negedge clk);
            sample++;
            c = cmd;
            a = addr;
            if (prev_req) begin
                if (prev_ack)
                    check(c != prev_cmd, "R4", "command changes after match", c, prev_cmd);
                else
                    check(c == prev_cmd && a == prev_addr, "R4", "command held", c, prev_cmd);
            end
            if (c != 4'd0 && prev_cmd == 4'd0) begin
                if (last_non == 4'hF)
                    check(nop_run == PWR_CYC, "R2", "power wait NOPs", nop_run, PWR_CYC);
                else if (last_non == 4'd2 && c == 4'd1)
                    check(nop_run == LOCK_CYC, "R5", "DLL lock NOPs", nop_run, LOCK_CYC);
                else if (last_non == 4'd3)
                    check(nop_run == TRFC_CYC, "R6", "refresh gap NOPs", nop_run, TRFC_CYC);
                else if (last_non == 4'd4)
                    check(nop_run == BURST && c == 4'd5, "R10", "write burst NOPs", nop_run, BURST);
            end
            if (c == 4'd0) nop_run++;
            else begin
                nop_run  = 0;
                last_non = c;
            end
            if (done && !done_seen) begin
                done_seen = 1'b1;
                check(sample == idle_sample + 1, "R7", "ready after idle", sample, idle_sample + 1);
            end
            if (done_seen)
                check(done == 1'b1, "R8", "ready sticky", done, 1);
            if (!done_seen)
                check(!(c == 4'd4 || c == 4'd5), "R9", "no data command before ready", c, 0);
            // model update
            prev_req = (c >= 4'd1 && c <= 4'd5);
            prev_ack = 1'b0;
            if (ctrl_state == 4'd0) begin
                if (prev_req) begin
                    if (stall > 0) stall--;
                    else begin
                        prev_ack = 1'b1;
                        if (acc_idx < 7) begin
                            check(c == exp_init_cmd(acc_idx), "R3", "init command", c, exp_init_cmd(acc_idx));
                            check(a == exp_init_addr(acc_idx), "R3", "init address", a, exp_init_addr(acc_idx));
                        end else begin
                            check(c == (((acc_idx - 7) % 2 == 0) ? 4'd4 : 4'd5), "R9", "write then read",
                                  c, (((acc_idx - 7) % 2 == 0) ? 4'd4 : 4'd5));
                            check(a == ADDR_W'((((acc_idx - 7) / 2) % 4)) << 21, "R11", "bank address",
                                  a, ADDR_W'((((acc_idx - 7) / 2) % 4)) << 21);
                            if (c == 4'd4) begin
                                exp_data = lfsr_next(exp_data);
                                check(wdata == exp_data, "R12", "write data", wdata, exp_data);
                            end
                        end
                        acc_idx++;
                        hold  = $urandom_range(1, 3);
                        stall = $urandom_range(0, 3);
                        if (c >= 4'd4) begin
                            ctrl_state = 4'd4;
                            pend_rw = c + 4'd2;
                        end else begin
                            ctrl_state = c;
                            if (c == 4'd2) loads++;
                        end
                    end
                end
            end else if (ctrl_state == 4'd4) begin
                ctrl_state = pend_rw;
            end else if (hold > 1) begin
                hold--;
            end else begin
                if (ctrl_state == 4'd2 && loads == 3) begin
                    idle_sample = sample;
                    check(done == 1'b0, "R7", "not ready while loading", done, 0);
                end
                ctrl_state = 4'd0;
            end
            prev_cmd  = c;
            prev_addr = a;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        fork
            begin
                repeat (3) @(negedge clk);
                check(cmd == 4'd0, "R1", "reset command", cmd, 0);
                check(done == 1'b0, "R1", "reset ready", done, 0);
                check(wdata == 8'h01, "R1", "reset seed", wdata, 8'h01);
                rst_n = 1'b1;
                @(posedge clk);
                mon_go = 1'b1;
                wait (done);
                repeat (10) @(negedge clk);
                // directed: long strobe pulse must still give one pair
                for (int k = 0; k < PAIRS; k++) begin
                    @(negedge clk);
                    strobe = 1'b1;
                    repeat ((k == 0) ? 120 : $urandom_range(30, 60)) @(negedge clk);
                    strobe = 1'b0;
                    repeat ($urandom_range(30, 60)) @(negedge clk);
                end
                repeat (20) @(negedge clk);
                check(acc_idx == 7 + 2 * PAIRS, "R11", "one pair per strobe", acc_idx, 7 + 2 * PAIRS);
                check(done == 1'b1, "R8", "ready at end", done, 1);
            end
            begin
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) check(1'b0, "R9", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule